// File: doc/BRIEF.md
# Clamp Switch Gate Timing Generator

This block produces the gate command for the auxiliary clamp switch of an isolated bidirectional full-bridge converter. It watches the digitized gate commands of the main switches. Each gate signal passes through a flop synchronizer, and its edges are found on the system clock. The block then forms the clamp gate according to the operating mode on `modeSel`.

In buck operation, a falling edge on any leading-leg gate starts a clamp pulse. The pulse width is given in clock cycles on `pulseWidth`, and a down-counter times it. In the two boost operations, which are start-up and regular boost, the block acts as an edge-driven set/reset latch on the two boost phase gates. A falling phase edge sets the clamp and a rising phase edge clears it. This single rule covers both sides of the 50 % duty point, where the clamp pulse moves relative to the main pulses. In idle mode, and on every mode change, the clamp is forced off and any running pulse is abandoned.

Top module: `clamp_gate_timer`

## Requirements
- R1: While `rstN` is low, and on its release, `clampGate` is 0.
- R2: With `modeSel`=1 (buck), a 1-to-0 change on any bit of `legGate` makes `clampGate` go to 1 at the third rising clock edge after the change. This is the two synchronizer stages plus the output register.
- R3: In buck mode, a pulse that is not retriggered keeps `clampGate` at 1 for exactly `pulseWidth` clock cycles.
- R4: In buck mode, a further leading-leg falling edge during a pulse reloads the width, so the pulse ends `pulseWidth` cycles after the new load.
- R5: In buck mode, when `pulseWidth` is 0, a leading-leg falling edge leaves `clampGate` at 0.
- R6: With `modeSel`=2 (boost start-up) or 3 (regular boost), a 1-to-0 change on any bit of `phaseGate` sets `clampGate` and a 0-to-1 change clears it. Each takes effect at the third rising edge after the input change, and both boost modes behave the same.
- R7: In a boost mode, if a set edge and a clear edge are detected in the same clock, `clampGate` is cleared.
- R8: With `modeSel`=0 (idle), `clampGate` stays 0 whatever the gate inputs do.
- R9: When `modeSel` changes, `clampGate` is 0 after the next rising edge, and a buck pulse in progress does not resume.
- R10: Rising edges of `legGate` have no effect in buck mode. `phaseGate` has no effect in buck mode, and `legGate` has no effect in the boost modes.
- R11: An input edge does not reach `clampGate` before the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| legGate | input | NUM_LEG (2) | Leading-leg main switch gate commands |
| phaseGate | input | NUM_PHASE (2) | Boost phase main switch gate commands |
| modeSel | input | 2 | 0 idle, 1 buck, 2 boost start-up, 3 regular boost |
| pulseWidth | input | WIDTH_W (16) | Buck clamp pulse width in clock cycles |
| clampGate | output | 1 | Clamp switch gate command |

## Verification
Two events can fall in the same clock: a latch set and a latch clear in boost, and a pulse retrigger together with a running countdown in buck. The boost collision is provoked by flipping one phase gate high and the other low on the same clock edge. Both edges then cross the synchronizers together, and the clamp must remain low. The buck overlap is provoked by a second leading-leg fall partway through a pulse. The clamp must then stay high past the original end and drop exactly one full width after the reload.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE        = 2'd0,
    MODE_BUCK        = 2'd1,
    MODE_BOOST_START = 2'd2,
    MODE_BOOST_RUN   = 2'd3
  } clamp_mode_e;

  // control -> datapath
  typedef struct packed {
    logic loadCnt;
    logic clearCnt;
  } cnt_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic legFall;
    logic phaseFall;
    logic phaseRise;
    logic cntDone;
    logic widthZero;
  } path_status_t;

endpackage

// File: rtl/clamp_gate_sync.sv
module clamp_gate_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] lvl,
  output logic [LANES-1:0] lvlQ
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], din[i]};
    end
    assign lvl[i] = chain[STAGES-1];
  end

  // one-cycle history of the synchronized level for edge finding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlQ <= '0;
    else       lvlQ <= lvl;
  end

endmodule

// File: rtl/clamp_edge_path.sv
module clamp_edge_path
  import clamp_pkg::*;
#(
  parameter int NUM_LEG     = 2,
  parameter int NUM_PHASE   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LEG-1:0]   legGate,
  input  logic [NUM_PHASE-1:0] phaseGate,
  input  logic [WIDTH_W-1:0]   pulseWidth,
  input  cnt_strobe_t          strobe,
  output path_status_t         status
);

  localparam logic [WIDTH_W-1:0] CNT_ONE = WIDTH_W'(1);

  logic [NUM_LEG-1:0]   legNow, legPrev;
  logic [NUM_PHASE-1:0] phaseNow, phasePrev;
  logic [WIDTH_W-1:0]   cnt;

  clamp_gate_sync #(.LANES(NUM_LEG), .STAGES(SYNC_STAGES)) u_legSync (
    .clk(clk), .rstN(rstN), .din(legGate), .lvl(legNow), .lvlQ(legPrev)
  );

  clamp_gate_sync #(.LANES(NUM_PHASE), .STAGES(SYNC_STAGES)) u_phaseSync (
    .clk(clk), .rstN(rstN), .din(phaseGate), .lvl(phaseNow), .lvlQ(phasePrev)
  );

  always_comb begin
    status.legFall   = |(legPrev & ~legNow);
    status.phaseFall = |(phasePrev & ~phaseNow);
    status.phaseRise = |(~phasePrev & phaseNow);
    status.cntDone   = (cnt == CNT_ONE);
    status.widthZero = (pulseWidth == '0);
  end

  // buck pulse width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.clearCnt) cnt <= '0;
    else if (strobe.loadCnt)  cnt <= pulseWidth;
    else if (cnt != '0)       cnt <= cnt - CNT_ONE;
  end

  // R4: a load strobe always restarts the count from the programmed width
  p_cnt_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCnt && !strobe.clearCnt) |=> (cnt == $past(pulseWidth)));

  // R9: clearing leaves no residual count
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (cnt == '0));

endmodule

// File: rtl/clamp_ctrl.sv
module clamp_ctrl
  import clamp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   modeSel,
  input  path_status_t status,
  output cnt_strobe_t  strobe,
  output logic         clampGate
);

  clamp_mode_e modeQ, modeIn;
  logic        modeChg, isBuck, isBoost, clampNext;

  assign modeIn  = clamp_mode_e'(modeSel);
  assign modeChg = (modeIn != modeQ);
  assign isBuck  = (modeQ == MODE_BUCK);
  assign isBoost = (modeQ == MODE_BOOST_START) || (modeQ == MODE_BOOST_RUN);

  always_comb begin
    strobe.clearCnt = modeChg || !isBuck;
    strobe.loadCnt  = !modeChg && isBuck && status.legFall;
  end

  always_comb begin
    clampNext = clampGate;
    if (modeChg) begin
      clampNext = 1'b0;
    end else begin
      unique case (modeQ)
        MODE_IDLE: clampNext = 1'b0;
        MODE_BUCK: begin
          if (status.legFall)      clampNext = !status.widthZero;
          else if (status.cntDone) clampNext = 1'b0;
        end
        MODE_BOOST_START, MODE_BOOST_RUN: begin
          if (status.phaseRise)      clampNext = 1'b0;  // clear has priority
          else if (status.phaseFall) clampNext = 1'b1;
        end
        default: clampNext = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_IDLE;
      clampGate <= 1'b0;
    end else begin
      modeQ     <= modeIn;
      clampGate <= clampNext;
    end
  end

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MODE_IDLE) |=> !clampGate);

  p_mode_change_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> !clampGate);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isBoost && !modeChg && status.phaseRise && status.phaseFall) |=> !clampGate);

  p_boost_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isBoost && !modeChg && status.phaseFall && !status.phaseRise) |=> clampGate);

  p_buck_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isBuck && !modeChg && !status.legFall && status.cntDone) |=> !clampGate);

  p_zero_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isBuck && !modeChg && status.legFall && status.widthZero) |=> !clampGate);

endmodule

// File: rtl/clamp_gate_timer.sv
module clamp_gate_timer
  import clamp_pkg::*;
#(
  parameter int NUM_LEG     = 2,
  parameter int NUM_PHASE   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LEG-1:0]   legGate,
  input  logic [NUM_PHASE-1:0] phaseGate,
  input  logic [1:0]           modeSel,
  input  logic [WIDTH_W-1:0]   pulseWidth,
  output logic                 clampGate
);

  cnt_strobe_t  strobe;
  path_status_t status;

  clamp_edge_path #(
    .NUM_LEG(NUM_LEG), .NUM_PHASE(NUM_PHASE),
    .SYNC_STAGES(SYNC_STAGES), .WIDTH_W(WIDTH_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .legGate(legGate), .phaseGate(phaseGate),
    .pulseWidth(pulseWidth), .strobe(strobe), .status(status)
  );

  clamp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .status(status),
    .strobe(strobe), .clampGate(clampGate)
  );

endmodule

// File: tb/sim_clamp_gate_timer.sv
`timescale 1ns/1ps
module sim_clamp_gate_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  legGate = '0;
  logic [1:0]  phaseGate = '0;
  logic [1:0]  modeSel = '0;
  logic [15:0] pulseWidth = 16'd5;
  logic        clampGate;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  clamp_gate_timer u0 (
    .clk(clk), .rstN(rstN), .legGate(legGate), .phaseGate(phaseGate),
    .modeSel(modeSel), .pulseWidth(pulseWidth), .clampGate(clampGate)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  leg;
    logic [1:0]  ph;
    logic [15:0] width;
    logic [3:0]  waitN;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 2'b00, 2'b00, 16'd5, 4'd4, 1'b0, 4'd9 },  // R9 enter regular boost
    '{2'd3, 2'b00, 2'b01, 16'd5, 4'd3, 1'b0, 4'd6 },  // R6 rise clears
    '{2'd3, 2'b00, 2'b00, 16'd5, 4'd2, 1'b0, 4'd11},  // R11 not yet
    '{2'd3, 2'b00, 2'b00, 16'd5, 4'd1, 1'b1, 4'd6 },  // R6 fall sets
    '{2'd3, 2'b00, 2'b10, 16'd5, 4'd3, 1'b0, 4'd6 },
    '{2'd3, 2'b00, 2'b00, 16'd5, 4'd3, 1'b1, 4'd6 },
    '{2'd3, 2'b11, 2'b00, 16'd5, 4'd3, 1'b1, 4'd10},  // R10 leg ignored
    '{2'd3, 2'b00, 2'b00, 16'd5, 4'd3, 1'b1, 4'd10},
    '{2'd2, 2'b00, 2'b00, 16'd5, 4'd1, 1'b0, 4'd9 },  // R9 change forces low
    '{2'd2, 2'b00, 2'b00, 16'd5, 4'd3, 1'b0, 4'd9 },
    '{2'd2, 2'b00, 2'b01, 16'd5, 4'd3, 1'b0, 4'd6 },
    '{2'd2, 2'b00, 2'b00, 16'd5, 4'd3, 1'b1, 4'd6 },  // R6 start-up sets
    '{2'd2, 2'b00, 2'b01, 16'd5, 4'd3, 1'b0, 4'd6 },
    '{2'd0, 2'b00, 2'b00, 16'd5, 4'd4, 1'b0, 4'd8 },  // R8 idle
    '{2'd0, 2'b00, 2'b11, 16'd5, 4'd3, 1'b0, 4'd8 },
    '{2'd0, 2'b00, 2'b00, 16'd5, 4'd3, 1'b0, 4'd8 },
    '{2'd1, 2'b00, 2'b11, 16'd5, 4'd2, 1'b0, 4'd9 },  // R9 enter buck
    '{2'd1, 2'b00, 2'b00, 16'd5, 4'd4, 1'b0, 4'd10},  // R10 phase ignored
    '{2'd1, 2'b01, 2'b00, 16'd5, 4'd3, 1'b0, 4'd10},  // R10 leg rise ignored
    '{2'd1, 2'b00, 2'b00, 16'd5, 4'd3, 1'b1, 4'd2 },  // R2 fall starts pulse
    '{2'd1, 2'b00, 2'b00, 16'd5, 4'd4, 1'b1, 4'd3 },  // R3 still high
    '{2'd1, 2'b00, 2'b00, 16'd5, 4'd1, 1'b0, 4'd3 },  // R3 ends after width
    '{2'd1, 2'b01, 2'b00, 16'd0, 4'd3, 1'b0, 4'd5 },
    '{2'd1, 2'b00, 2'b00, 16'd0, 4'd3, 1'b0, 4'd5 },  // R5 zero width
    '{2'd1, 2'b00, 2'b00, 16'd0, 4'd2, 1'b0, 4'd5 }
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (clampGate !== exp) begin
      failures++;
      $display("FAIL %s: clampGate=%0b expected=%0b at %0t", tag, clampGate, exp, $time);
    end
  endtask

  task automatic waitSample(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1 reset state
    waitSample(3);
    check(1'b0, "R1 during reset");
    @(negedge clk) rstN = 1'b1;
    waitSample(1);
    check(1'b0, "R1 after release");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      modeSel = VEC[i].mode;
      legGate = VEC[i].leg;
      phaseGate = VEC[i].ph;
      pulseWidth = VEC[i].width;
      waitSample(int'(VEC[i].waitN));
      check(VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R7: phase X rises while phase Y falls in the same cycle
    @(negedge clk) begin modeSel = 2'd3; legGate = 2'b00; phaseGate = 2'b00; end
    waitSample(3);
    @(negedge clk) phaseGate = 2'b10;
    waitSample(3);
    check(1'b0, "R6 Y rise clears");
    @(negedge clk) phaseGate = 2'b01;
    waitSample(3);
    check(1'b0, "R7 clear wins over set");
    waitSample(2);
    check(1'b0, "R7 stays clear");
    @(negedge clk) phaseGate = 2'b00;
    waitSample(3);
    check(1'b1, "R6 set after collision");

    // R4: retrigger inside a buck pulse
    @(negedge clk) begin modeSel = 2'd1; phaseGate = 2'b00; pulseWidth = 16'd6; end
    waitSample(2);
    @(negedge clk) legGate = 2'b01;
    waitSample(3);
    @(negedge clk) legGate = 2'b00;
    waitSample(3);
    check(1'b1, "R2 buck pulse start");
    @(negedge clk) legGate = 2'b01;
    @(negedge clk) legGate = 2'b00;
    waitSample(7);
    check(1'b1, "R4 retrigger extends pulse");
    waitSample(1);
    check(1'b1, "R4 last cycle of reloaded pulse");
    waitSample(1);
    check(1'b0, "R4 reloaded pulse ends");

    // R9: mode change in mid-pulse abandons it
    @(negedge clk) begin legGate = 2'b10; pulseWidth = 16'd20; end
    waitSample(3);
    @(negedge clk) legGate = 2'b00;
    waitSample(3);
    check(1'b1, "R2 long pulse start");
    @(negedge clk) modeSel = 2'd2;
    waitSample(1);
    check(1'b0, "R9 mode change clears pulse");
    @(negedge clk) modeSel = 2'd1;
    waitSample(6);
    check(1'b0, "R9 pulse does not resume");

    // R1: reset while the boost latch is set
    @(negedge clk) begin modeSel = 2'd3; phaseGate = 2'b01; end
    waitSample(4);
    @(negedge clk) phaseGate = 2'b00;
    waitSample(3);
    check(1'b1, "R6 set before reset");
    @(negedge clk) rstN = 1'b0;
    #1;
    check(1'b0, "R1 asynchronous reset");
    @(negedge clk) rstN = 1'b1;
    waitSample(4);
    check(1'b0, "R1 low after release");

    finish_run();
  end

endmodule